// File: doc/BRIEF.md
# Audio DSP Multiply-Accumulate and Output Shifter

This block is the arithmetic core of one step of a sample-rate audio effects processor. Each step takes a signed 24-bit multiplicand and a signed 13-bit coefficient and forms their full-precision product. It scales the product down by 12 bits, adds a signed 26-bit addend, and keeps the result in a 26-bit accumulator. The addend can be suppressed. Operand selection and memory addressing live in neighbouring blocks. This block only consumes the operands it is handed.

An output shifter reads the accumulator as it stood before the current step's update. The adder result therefore reaches the shifter one step late. The shifter applies one of four scalings and presents the result as the value the temp RAM would store. The same result feeds three write-back targets: a fraction register, an address register and a small bank of effect output registers. How the fraction and address loads interpret their source depends on the selected scaling mode. At the start of each program pass, a clear pulse zeroes the accumulator, the fraction register and the address register.

Top module: `dsp_mac_shift`

## Requirements
- R1: On a clock edge with `step_en` high and `pass_clr` low, `acc_out` becomes ((x_in × y_in) arithmetically shifted right by 12) + b_in. The product is taken at 37-bit signed precision and the sum wraps to 26 bits.
- R2: When `zero_b` is 1 during such a step, b_in is not added and `acc_out` becomes the scaled product alone.
- R3: `shifted_out` is computed combinationally from the accumulator register. It therefore reflects the value from before the current step's update, and every write-back load taken at an edge uses that earlier value.
- R4: With `shift_mode` = 0, `shifted_out` is the accumulator clamped to the range −8388608 to 8388607.
- R5: With `shift_mode` = 1, `shifted_out` is twice the accumulator, computed without loss and then clamped to the same 24-bit signed range.
- R6: With `shift_mode` = 2, `shifted_out` is twice the accumulator wrapped to 26 bits, with no clamping.
- R7: With `shift_mode` = 3, `shifted_out` equals the accumulator unchanged.
- R8: On a step with `frc_ld` set, `frc_out` (13 bits) loads the zero-extended low 12 bits of `shifted_out` in mode 3. In any other mode it loads `shifted_out` arithmetically shifted right by 11, truncated to 13 bits. Without a load it holds.
- R9: On a step with `adr_ld` set, `adr_out` (14 bits) loads `shifted_out` arithmetically shifted right by 12 in mode 3. In any other mode it loads `inputs_in` (signed 24-bit) arithmetically shifted right by 16, sign-extended to 14 bits. Without a load it holds.
- R10: On a step with `ef_wr` set, entry `ef_idx` of the effect bank loads `shifted_out` arithmetically shifted right by 8 (18 bits). Entry k occupies bits [18k+17:18k] of `ef_out`. All other entries hold.
- R11: `pass_clr` zeroes the accumulator, fraction and address registers at the next edge and takes priority over `step_en`. No load happens in that cycle, and the effect bank is left unchanged.
- R12: With `step_en` low and `pass_clr` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| pass_clr | input | 1 | Start-of-pass clear |
| step_en | input | 1 | Execute one step at this edge |
| x_in | input | 24 | Signed multiplicand |
| y_in | input | 13 | Signed coefficient |
| b_in | input | 26 | Signed addend |
| zero_b | input | 1 | Suppress the addend |
| shift_mode | input | 2 | Output scaling mode 0..3 |
| inputs_in | input | 24 | Signed input-bus value for address loads |
| frc_ld | input | 1 | Load fraction register |
| adr_ld | input | 1 | Load address register |
| ef_wr | input | 1 | Write one effect register |
| ef_idx | input | 4 | Effect register index |
| acc_out | output | 26 | Accumulator |
| shifted_out | output | 26 | Shifter result (temp RAM write value) |
| frc_out | output | 13 | Fraction register |
| adr_out | output | 14 | Address register |
| ef_out | output | 288 | Effect register bank, entry k at [18k+17:18k] |

## Verification
The accumulator update and the write-back loads taken from the shifter fall on the same edge. A correct design must feed the loads from the accumulator value that existed before that edge. The bench provokes this with steps that change the accumulator while also asserting the fraction, address and effect loads. The loaded values are judged against a model that captures the shifter output before the model's accumulator is advanced. A second overlap, a pass clear arriving together with a step and its loads, is mixed into the random stream and must leave only zeros and held values.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
    parameter int XW      = 24;           // multiplicand width
    parameter int YW      = 13;           // coefficient width
    parameter int AW      = 26;           // accumulator width
    parameter int FRAC    = 12;           // product scale-down
    parameter int SATW    = 24;           // saturation width
    parameter int IW      = 24;           // input bus width
    parameter int FRC_W   = 13;
    parameter int FRC_RAW = 12;           // low bits kept in raw mode
    parameter int FRC_SH  = 11;
    parameter int ADR_W   = 14;
    parameter int ADR_SH  = 12;
    parameter int IN_SH   = 16;
    parameter int EF_SH   = 8;
    parameter int EF_W    = AW - EF_SH;
    parameter int PW      = XW + YW;

    typedef enum logic [1:0] {
        SH_CLAMP     = 2'd0,
        SH_DBL_CLAMP = 2'd1,
        SH_DBL_WRAP  = 2'd2,
        SH_RAW       = 2'd3
    } shift_mode_e;

    typedef struct packed {
        logic frc_ld;
        logic adr_ld;
        logic ef_wr;
    } wb_en_t;

    localparam logic signed [AW:0] SAT_HI = (AW+1)'((64'sd1 <<< (SATW-1)) - 1);
    localparam logic signed [AW:0] SAT_LO = (AW+1)'(-(64'sd1 <<< (SATW-1)));

    function automatic logic signed [AW-1:0] clamp_sat(input logic signed [AW:0] v);
        logic signed [AW:0] r;
        if (v > SAT_HI)      r = SAT_HI;
        else if (v < SAT_LO) r = SAT_LO;
        else                 r = v;
        return r[AW-1:0];
    endfunction
endpackage

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
    import dsp_mac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step_en,
    input  logic signed [XW-1:0] x,
    input  logic signed [YW-1:0] y,
    input  logic signed [AW-1:0] b,
    input  logic                 zero_b,
    output logic signed [AW-1:0] acc_q
);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [AW-1:0] addend;
    logic signed [AW-1:0] acc_next;

    always_comb begin
        prod     = PW'(x) * PW'(y);
        scaled   = prod >>> FRAC;
        addend   = zero_b ? '0 : b;
        acc_next = scaled[AW-1:0] + addend;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   acc_q <= '0;
        else if (step_en) acc_q <= acc_next;
    end

    p_acc_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step_en) |=> $stable(acc_q));
    p_acc_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));
endmodule

// File: rtl/dsp_out_shifter.sv
module dsp_out_shifter
    import dsp_mac_pkg::*;
(
    input  logic signed [AW-1:0] acc,
    input  shift_mode_e          mode,
    output logic signed [AW-1:0] shifted
);
    logic signed [AW:0] wide;
    logic signed [AW:0] dbl;

    always_comb begin
        wide = (AW+1)'(acc);
        dbl  = wide <<< 1;
        unique case (mode)
            SH_CLAMP:     shifted = clamp_sat(wide);
            SH_DBL_CLAMP: shifted = clamp_sat(dbl);
            SH_DBL_WRAP:  shifted = dbl[AW-1:0];
            default:      shifted = acc;
        endcase
    end
endmodule

// File: rtl/dsp_wb_regs.sv
module dsp_wb_regs
    import dsp_mac_pkg::*;
#(
    parameter int NUM_EF = 16,
    localparam int EIW   = $clog2(NUM_EF)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     step_en,
    input  shift_mode_e              mode,
    input  logic signed [AW-1:0]     shifted,
    input  logic signed [IW-1:0]     in_val,
    input  wb_en_t                   en,
    input  logic [EIW-1:0]           ef_idx,
    output logic signed [FRC_W-1:0]  frc_q,
    output logic signed [ADR_W-1:0]  adr_q,
    output logic [NUM_EF*EF_W-1:0]   ef_flat
);
    logic signed [AW-1:0]    frc_sh, adr_sh, ef_sh;
    logic signed [IW-1:0]    in_sh;
    logic signed [FRC_W-1:0] frc_next;
    logic signed [ADR_W-1:0] adr_next;
    logic                    go;

    always_comb begin
        go       = step_en && !clr;
        frc_sh   = shifted >>> FRC_SH;
        adr_sh   = shifted >>> ADR_SH;
        ef_sh    = shifted >>> EF_SH;
        in_sh    = in_val >>> IN_SH;
        frc_next = (mode == SH_RAW) ? FRC_W'(shifted[FRC_RAW-1:0]) : frc_sh[FRC_W-1:0];
        adr_next = (mode == SH_RAW) ? adr_sh[ADR_W-1:0] : in_sh[ADR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            frc_q <= '0;
            adr_q <= '0;
        end else if (go) begin
            if (en.frc_ld) frc_q <= frc_next;
            if (en.adr_ld) adr_q <= adr_next;
        end
    end

    for (genvar k = 0; k < NUM_EF; k++) begin : g_ef
        always_ff @(posedge clk) begin
            if (rst)
                ef_flat[k*EF_W +: EF_W] <= '0;
            else if (go && en.ef_wr && (ef_idx == EIW'(k)))
                ef_flat[k*EF_W +: EF_W] <= ef_sh[EF_W-1:0];
        end
    end

    p_frc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(step_en && en.frc_ld)) |=> $stable(frc_q));
    p_adr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(step_en && en.adr_ld)) |=> $stable(adr_q));
    p_adr_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> (adr_q == '0 && frc_q == '0));
    p_ef_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (clr || !(step_en && en.ef_wr)) |=> $stable(ef_flat));
endmodule

// File: rtl/dsp_mac_shift.sv
module dsp_mac_shift
    import dsp_mac_pkg::*;
#(
    parameter int NUM_EF = 16,
    localparam int EIW   = $clog2(NUM_EF)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pass_clr,
    input  logic                    step_en,
    input  logic signed [XW-1:0]    x_in,
    input  logic signed [YW-1:0]    y_in,
    input  logic signed [AW-1:0]    b_in,
    input  logic                    zero_b,
    input  logic [1:0]              shift_mode,
    input  logic signed [IW-1:0]    inputs_in,
    input  logic                    frc_ld,
    input  logic                    adr_ld,
    input  logic                    ef_wr,
    input  logic [EIW-1:0]          ef_idx,
    output logic signed [AW-1:0]    acc_out,
    output logic signed [AW-1:0]    shifted_out,
    output logic signed [FRC_W-1:0] frc_out,
    output logic signed [ADR_W-1:0] adr_out,
    output logic [NUM_EF*EF_W-1:0]  ef_out
);
    shift_mode_e mode;
    wb_en_t      wb_en;

    always_comb begin
        mode  = shift_mode_e'(shift_mode);
        wb_en = '{frc_ld: frc_ld, adr_ld: adr_ld, ef_wr: ef_wr};
    end

    dsp_acc_unit u_acc (
        .clk(clk), .rst(rst), .clr(pass_clr), .step_en(step_en),
        .x(x_in), .y(y_in), .b(b_in), .zero_b(zero_b), .acc_q(acc_out)
    );

    dsp_out_shifter u_shift (
        .acc(acc_out), .mode(mode), .shifted(shifted_out)
    );

    dsp_wb_regs #(.NUM_EF(NUM_EF)) u_wb (
        .clk(clk), .rst(rst), .clr(pass_clr), .step_en(step_en),
        .mode(mode), .shifted(shifted_out), .in_val(inputs_in),
        .en(wb_en), .ef_idx(ef_idx),
        .frc_q(frc_out), .adr_q(adr_out), .ef_flat(ef_out)
    );

    p_sat_range_r4: assert property (@(posedge clk) disable iff (rst)
        (shift_mode == 2'd0) |-> ((AW+1)'(shifted_out) <= SAT_HI && (AW+1)'(shifted_out) >= SAT_LO));
    p_sat_range_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_mode == 2'd1) |-> ((AW+1)'(shifted_out) <= SAT_HI && (AW+1)'(shifted_out) >= SAT_LO));
    p_raw_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (shift_mode == 2'd3) |-> (shifted_out == acc_out));
endmodule

// File: tb/dsp_mac_shift_bench.sv
module dsp_mac_shift_bench;
    localparam int CLK_P  = 10;
    localparam int NUM_EF = 16;
    localparam int EFW    = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pass_clr = 1'b0, step_en = 1'b0, zero_b = 1'b0;
    logic signed [23:0] x_in = '0;
    logic signed [12:0] y_in = '0;
    logic signed [25:0] b_in = '0;
    logic [1:0]  shift_mode = '0;
    logic signed [23:0] inputs_in = '0;
    logic frc_ld = 1'b0, adr_ld = 1'b0, ef_wr = 1'b0;
    logic [3:0] ef_idx = '0;
    logic signed [25:0] acc_out, shifted_out;
    logic signed [12:0] frc_out;
    logic signed [13:0] adr_out;
    logic [NUM_EF*EFW-1:0] ef_out;

    always #(CLK_P/2) clk = ~clk;

    dsp_mac_shift #(.NUM_EF(NUM_EF)) u_dsp_mac_shift (
        .clk(clk), .rst(rst), .pass_clr(pass_clr), .step_en(step_en),
        .x_in(x_in), .y_in(y_in), .b_in(b_in), .zero_b(zero_b),
        .shift_mode(shift_mode), .inputs_in(inputs_in),
        .frc_ld(frc_ld), .adr_ld(adr_ld), .ef_wr(ef_wr), .ef_idx(ef_idx),
        .acc_out(acc_out), .shifted_out(shifted_out), .frc_out(frc_out),
        .adr_out(adr_out), .ef_out(ef_out)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    longint acc_m, frc_m, adr_m;
    longint ef_m [NUM_EF];

    function automatic longint wrapn(longint v, int n);
        longint m = v & ((64'sd1 <<< n) - 1);
        if (m >= (64'sd1 <<< (n-1))) m = m - (64'sd1 <<< n);
        return m;
    endfunction

    function automatic longint clamp24(longint v);
        if (v > 8388607) return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    function automatic longint exp_shift(longint a, int m);
        case (m)
            0: return clamp24(a);
            1: return clamp24(2*a);
            2: return wrapn(2*a, 26);
            default: return a;
        endcase
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Called at a negedge with inputs already driven.
    task automatic run_cycle();
        longint s, sh, nacc;
        string tg;
        #1;
        s = exp_shift(acc_m, shift_mode);
        case (shift_mode)
            2'd0: tg = "R4 R3";
            2'd1: tg = "R5 R3";
            2'd2: tg = "R6 R3";
            default: tg = "R7 R3";
        endcase
        chk(tg, shifted_out, s);
        if (pass_clr) begin
            acc_m = 0; frc_m = 0; adr_m = 0;
        end else if (step_en) begin
            nacc = ((longint'(x_in) * longint'(y_in)) >>> 12) + (zero_b ? 0 : longint'(b_in));
            if (frc_ld) frc_m = (shift_mode == 2'd3) ? (s & 12'hFFF) : wrapn(s >>> 11, 13);
            if (adr_ld) begin
                sh = (shift_mode == 2'd3) ? (s >>> 12) : (longint'(inputs_in) >>> 16);
                adr_m = wrapn(sh, 14);
            end
            if (ef_wr) ef_m[ef_idx] = wrapn(s >>> 8, 18);
            acc_m = wrapn(nacc, 26);
        end
        @(posedge clk);
        @(negedge clk);
        tg = pass_clr ? "R11" : (!step_en ? "R12" : (zero_b ? "R2" : "R1"));
        chk(tg, acc_out, acc_m);
        chk(pass_clr ? "R11" : "R8 R3", frc_out, frc_m);
        chk(pass_clr ? "R11" : "R9 R3", adr_out, adr_m);
        for (int k = 0; k < NUM_EF; k++) begin
            longint a = longint'($signed(ef_out[k*EFW +: EFW]));
            if (a != ef_m[k]) begin
                chk("R10", a, ef_m[k]);
                break;
            end
            if (k == NUM_EF-1) chk("R10", a, ef_m[k]);
        end
    endtask

    task automatic set_in(bit clr, bit st, longint x, longint y, longint b, bit z,
                          int md, longint inp, bit fl, bit al, bit ew, int ix);
        pass_clr = clr; step_en = st; x_in = 24'(x); y_in = 13'(y); b_in = 26'(b);
        zero_b = z; shift_mode = 2'(md); inputs_in = 24'(inp);
        frc_ld = fl; adr_ld = al; ef_wr = ew; ef_idx = 4'(ix);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        longint loads [8];
        int seed;
        seed = $urandom(32'd4242);
        acc_m = 0; frc_m = 0; adr_m = 0;
        for (int k = 0; k < NUM_EF; k++) ef_m[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R12", acc_out, 0);
        chk("R12", shifted_out, 0);
        chk("R8", frc_out, 0);
        chk("R9", adr_out, 0);
        chk("R10", ef_out == '0, 1);

        // R1 product corner: most negative operands
        set_in(0, 1, -8388608, -4096, 5, 0, 3, 0, 0, 0, 0, 0); run_cycle();
        // R2 addend suppressed
        set_in(0, 1, 1234567, 777, 9999, 1, 3, 0, 0, 0, 0, 0); run_cycle();
        // R1 wrap: large addend plus positive product
        set_in(0, 1, 8388607, 4095, 33554431, 0, 3, 0, 0, 0, 0, 0); run_cycle();

        // Each mode against boundary accumulator values, with loads in same step (R3)
        loads = '{33554431, -33554432, 8388607, 8388608, -8388609, 4194304, -4194305, 74565};
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 8; i++) begin
                set_in(0, 1, 0, 0, loads[i], 0, m, 0, 0, 0, 0, 0); run_cycle();
                set_in(0, 1, 1000, 2000, -loads[i], 0, m, -8388608 + i*1000003,
                       1, 1, 1, (m*8+i) % NUM_EF);
                run_cycle();
            end
        end

        // R12 idle with all enables set
        set_in(0, 0, 555, 666, 777, 0, 1, 4095, 1, 1, 1, 3); run_cycle();
        // R11 clear together with step and loads
        set_in(1, 1, 555, 666, 777, 0, 3, 4095, 1, 1, 1, 4); run_cycle();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            set_in(($urandom % 32) == 0, ($urandom % 8) != 0,
                   longint'($signed(24'($urandom))), longint'($signed(13'($urandom))),
                   longint'($signed(26'($urandom))), ($urandom % 4) == 0,
                   $urandom % 4, longint'($signed(24'($urandom))),
                   $urandom % 2, $urandom % 2, $urandom % 2, $urandom % NUM_EF);
            run_cycle();
        end
        finish_up();
    end
endmodule